// File: doc/BRIEF.md
# Priority Pause Retransmission Hold-Off Timer

This block decides, separately for each of eight traffic priorities, whether a fresh pause (XOFF) frame for that priority may be sent now. Each time the transmitter reports that an XOFF frame went out for a priority that is still congested, the block blocks further retransmissions for a hold-off interval. The interval is the larger of two optional delays: one configured per priority and one shared by all priorities. A disabled delay counts as zero. Both delays are given in pause quanta, where one quantum is 512 bit times. A quantum therefore lasts two clock cycles on a 256-bit datapath and one cycle on a 512-bit datapath.

A free-running quanta prescaler gives one tick per quantum. Each priority runs a small state machine that has three states:
- `HO_IDLE`: the priority is not requesting pause.
- `HO_READY`: the priority is requesting pause and retransmission is allowed.
- `HO_HOLD`: a down-counter of quanta is running and retransmission is blocked.

The transitions are as follows:
- Any state goes to `HO_IDLE` whenever the request is low. This clears the counter.
- `HO_IDLE` goes to `HO_READY` when the request rises without a send.
- `HO_IDLE` or `HO_READY` goes to `HO_HOLD` on a send while the effective hold-off is non-zero.
- Any requesting state goes to `HO_READY` on a send while the effective hold-off is zero.
- `HO_HOLD` goes back into `HO_HOLD` on a send, which reloads the counter.
- `HO_HOLD` goes to `HO_READY` on the quanta tick that finishes the count.

Top module: `pfc_holdoff_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bit of `retx_ok` is 1.
- R2: The effective hold-off for priority i is max(A, B). A is the 16-bit slice `queue_hold_quanta[16*i+15:16*i]` when `queue_hold_en[i]` is 1, and 0 otherwise. B is `global_hold_quanta` when `global_hold_en` is 1, and 0 otherwise.
- R3: If the effective hold-off is 0, a send strobe leaves `retx_ok[i]` at 1 on every cycle. This also covers an enabled value of 0.
- R4: A send strobe on priority i, sampled at clock edge s while `xoff_req[i]` is 1 and the effective hold-off N is non-zero, drives `retx_ok[i]` to 0 from edge s. It stays 0 until the edge of the N-th quanta tick after edge s, where it returns to 1.
- R5: A quantum lasts 512/`DATAPATH_BITS` clock cycles. The prescaler restarts at reset. Counting edges from 1 at the first edge with reset released, a tick occurs at edge e exactly when e is a multiple of 512/`DATAPATH_BITS`.
- R6: Dropping `xoff_req[i]` makes `retx_ok[i]` 1 from the next edge and discards the remaining count. A later re-request without a send keeps `retx_ok[i]` at 1.
- R7: Each priority's hold-off is independent. A hold on one priority never changes `retx_ok` of another.
- R8: A send strobe on priority i while `xoff_req[i]` is 0 is ignored. `retx_ok[i]` stays 1, and it stays 1 after the request is later raised.
- R9: A send strobe during an active hold reloads the counter with the current effective hold-off. The timing of R4 is then measured from that new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the transmit MAC |
| rst_n | input | 1 | Active-low synchronous reset |
| xoff_req | input | NUM_PRIO | Per-priority congestion (XOFF wanted) request |
| frame_sent | input | NUM_PRIO | Per-priority one-cycle strobe: an XOFF frame was sent |
| queue_hold_en | input | NUM_PRIO | Per-priority enable of its own hold-off value |
| queue_hold_quanta | input | NUM_PRIO*QW | Per-priority hold-off in quanta, priority i in bits [QW*i+QW-1:QW*i] |
| global_hold_en | input | 1 | Enable of the hold-off shared by all priorities |
| global_hold_quanta | input | QW | Shared hold-off in quanta |
| retx_ok | output | NUM_PRIO | 1 when a new XOFF frame for that priority may be sent |

## Verification
`retx_ok` is a decode of the registered state, so a send strobe or a request drop shows up one edge later. It is read in the middle of the low clock phase that follows. A hold that starts at edge s ends at edge L, where L is the N-th multiple of the cycles-per-quantum after s. The bench computes L from its own count of edges since reset. It counts the low samples, expects exactly L−s of them, and checks this for both datapath widths at once. Sweeps over both enables and several per-queue and global values cover the cases where the maximum is taken, a value is disabled, or a value is zero.

// File: rtl/pfc_holdoff_pkg.sv
package pfc_holdoff_pkg;

    // Per-priority hold-off controller states
    typedef enum logic [1:0] {
        HO_IDLE  = 2'd0,   // no pause request for this priority
        HO_READY = 2'd1,   // requesting, retransmission allowed
        HO_HOLD  = 2'd2    // requesting, hold-off counter running
    } ho_state_e;

    localparam int QUANTA_BITS = 512;

endpackage

// File: rtl/pfc_quanta_prescaler.sv
module pfc_quanta_prescaler #(
    parameter int CPQ = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic quanta_tick
);

    generate
        if (CPQ <= 1) begin : g_every_cycle
            // One quantum per clock: every edge is a tick.
            assign quanta_tick = 1'b1;
        end else begin : g_divided
            localparam int CW = $clog2(CPQ);
            localparam logic [CW-1:0] LAST = CW'(CPQ - 1);
            logic [CW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign quanta_tick = (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/pfc_holdoff_select.sv
module pfc_holdoff_select #(
    parameter int QW = 16
) (
    input  logic          queue_en,
    input  logic [QW-1:0] queue_quanta,
    input  logic          global_en,
    input  logic [QW-1:0] global_quanta,
    output logic [QW-1:0] eff_quanta
);

    logic [QW-1:0] q_term;
    logic [QW-1:0] g_term;

    always_comb begin
        q_term     = queue_en  ? queue_quanta  : '0;
        g_term     = global_en ? global_quanta : '0;
        eff_quanta = (q_term > g_term) ? q_term : g_term;
    end

endmodule

// File: rtl/pfc_queue_holdoff_fsm.sv
module pfc_queue_holdoff_fsm
    import pfc_holdoff_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          quanta_tick,
    input  logic          xoff_req,
    input  logic          frame_sent,
    input  logic [QW-1:0] hold_quanta,
    output logic          retx_ok
);

    ho_state_e     state_q;
    ho_state_e     state_d;
    logic [QW-1:0] cnt_q;
    logic [QW-1:0] cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!xoff_req) begin
            state_d = HO_IDLE;
            cnt_d   = '0;
        end else if (frame_sent) begin
            if (hold_quanta == '0) begin
                state_d = HO_READY;
                cnt_d   = '0;
            end else begin
                state_d = HO_HOLD;
                cnt_d   = hold_quanta;
            end
        end else begin
            unique case (state_q)
                HO_IDLE:  state_d = HO_READY;
                HO_READY: state_d = HO_READY;
                HO_HOLD: begin
                    if (quanta_tick) begin
                        if (cnt_q <= QW'(1)) begin
                            state_d = HO_READY;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = HO_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            HO_HOLD: retx_ok = 1'b0;
            default: retx_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/pfc_holdoff_timer.sv
module pfc_holdoff_timer #(
    parameter int NUM_PRIO      = 8,
    parameter int QW            = 16,
    parameter int DATAPATH_BITS = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PRIO-1:0]    xoff_req,
    input  logic [NUM_PRIO-1:0]    frame_sent,
    input  logic [NUM_PRIO-1:0]    queue_hold_en,
    input  logic [NUM_PRIO*QW-1:0] queue_hold_quanta,
    input  logic                   global_hold_en,
    input  logic [QW-1:0]          global_hold_quanta,
    output logic [NUM_PRIO-1:0]    retx_ok
);

    localparam int CPQ = pfc_holdoff_pkg::QUANTA_BITS / DATAPATH_BITS;

    logic quanta_tick;

    pfc_quanta_prescaler #(.CPQ(CPQ)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .quanta_tick (quanta_tick)
    );

    generate
        for (genvar i = 0; i < NUM_PRIO; i++) begin : g_prio
            logic [QW-1:0] eff_quanta;

            pfc_holdoff_select #(.QW(QW)) u_sel (
                .queue_en      (queue_hold_en[i]),
                .queue_quanta  (queue_hold_quanta[QW*i +: QW]),
                .global_en     (global_hold_en),
                .global_quanta (global_hold_quanta),
                .eff_quanta    (eff_quanta)
            );

            pfc_queue_holdoff_fsm #(.QW(QW)) u_fsm (
                .clk         (clk),
                .rst_n       (rst_n),
                .quanta_tick (quanta_tick),
                .xoff_req    (xoff_req[i]),
                .frame_sent  (frame_sent[i]),
                .hold_quanta (eff_quanta),
                .retx_ok     (retx_ok[i])
            );
        end
    endgenerate

endmodule

// File: rtl/pfc_holdoff_checker.sv
module pfc_holdoff_checker #(
    parameter int NUM_PRIO = 8,
    parameter int QW       = 16,
    parameter int CPQ      = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   quanta_tick,
    input logic [NUM_PRIO-1:0]    xoff_req,
    input logic [NUM_PRIO-1:0]    frame_sent,
    input logic [NUM_PRIO-1:0]    queue_hold_en,
    input logic [NUM_PRIO*QW-1:0] queue_hold_quanta,
    input logic                   global_hold_en,
    input logic [QW-1:0]          global_hold_quanta,
    input logic [NUM_PRIO-1:0]    retx_ok
);

    // Reset releases every priority (R1)
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_open_R1: assert (&retx_ok);
        end
    end

    generate
        if (CPQ > 1) begin : g_tick_gap
            // Two ticks never fall on adjacent edges when a quantum spans cycles (R5)
            assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
                quanta_tick |=> !quanta_tick);
        end

        for (genvar i = 0; i < NUM_PRIO; i++) begin : g_q
            logic nz;
            assign nz = (queue_hold_en[i] && (queue_hold_quanta[QW*i +: QW] != '0)) ||
                        (global_hold_en && (global_hold_quanta != '0));

            assert_drop_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !xoff_req[i] |=> retx_ok[i]);

            assert_send_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (xoff_req[i] && frame_sent[i] && nz) |=> !retx_ok[i]);

            assert_zero_hold_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (xoff_req[i] && frame_sent[i] && !nz) |=> retx_ok[i]);

            assert_hold_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!retx_ok[i] && xoff_req[i] && !quanta_tick && !frame_sent[i]) |=> !retx_ok[i]);

            assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(retx_ok[i]) && $past(xoff_req[i])) |-> $past(quanta_tick));
        end
    endgenerate

endmodule

bind pfc_holdoff_timer pfc_holdoff_checker #(
    .NUM_PRIO (NUM_PRIO),
    .QW       (QW),
    .CPQ      (CPQ)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .quanta_tick        (quanta_tick),
    .xoff_req           (xoff_req),
    .frame_sent         (frame_sent),
    .queue_hold_en      (queue_hold_en),
    .queue_hold_quanta  (queue_hold_quanta),
    .global_hold_en     (global_hold_en),
    .global_hold_quanta (global_hold_quanta),
    .retx_ok            (retx_ok)
);

// File: tb/pfc_holdoff_timer_tb_top.sv
module pfc_holdoff_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int QW  = 16;
    localparam int CPQ_N = 2;   // 256-bit datapath
    localparam int CPQ_W = 1;   // 512-bit datapath

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   xoff_req = '0;
    logic [NP-1:0]   frame_sent = '0;
    logic [NP-1:0]   queue_hold_en = '0;
    logic [QW-1:0]   qq [NP];
    logic [NP*QW-1:0] queue_hold_quanta;
    logic            global_hold_en = 1'b0;
    logic [QW-1:0]   global_hold_quanta = '0;
    logic [NP-1:0]   ok_n;
    logic [NP-1:0]   ok_w;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) queue_hold_quanta[QW*i +: QW] = qq[i];
    end

    always_ff @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    pfc_holdoff_timer #(.NUM_PRIO(NP), .QW(QW), .DATAPATH_BITS(256)) dut_i (
        .clk(clk), .rst_n(rst_n), .xoff_req(xoff_req), .frame_sent(frame_sent),
        .queue_hold_en(queue_hold_en), .queue_hold_quanta(queue_hold_quanta),
        .global_hold_en(global_hold_en), .global_hold_quanta(global_hold_quanta),
        .retx_ok(ok_n));

    pfc_holdoff_timer #(.NUM_PRIO(NP), .QW(QW), .DATAPATH_BITS(512)) dut_wide_i (
        .clk(clk), .rst_n(rst_n), .xoff_req(xoff_req), .frame_sent(frame_sent),
        .queue_hold_en(queue_hold_en), .queue_hold_quanta(queue_hold_quanta),
        .global_hold_en(global_hold_en), .global_hold_quanta(global_hold_quanta),
        .retx_ok(ok_w));

    task automatic chk(input bit good, input string req, input int act, input int expv);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Low samples expected for a hold of n quanta loaded at edge s (R4, R5)
    function automatic int exp_low(input int s, input int n, input int cpq);
        int first;
        if (n == 0) return 0;
        first = ((s / cpq) + 1) * cpq;
        return first + (n - 1) * cpq - s;
    endfunction

    function automatic int eff(input bit qe, input int qv, input bit ge, input int gv);
        int a, b;
        a = qe ? qv : 0;
        b = ge ? gv : 0;
        return (a > b) ? a : b;
    endfunction

    // Pulse a send on q at this negedge; count low samples on both widths
    task automatic send_and_measure(input int q, input int n, input string req);
        int s, ln, lw;
        s = cyc + 1;
        frame_sent[q] = 1'b1;
        @(negedge clk);
        frame_sent[q] = 1'b0;
        ln = 0; lw = 0;
        for (int k = 0; k < 200; k++) begin
            if (!ok_n[q]) ln++;
            if (!ok_w[q]) lw++;
            if (ok_n[q] && ok_w[q]) break;
            @(negedge clk);
        end
        chk(ln == exp_low(s, n, CPQ_N), {req, " 256b"}, ln, exp_low(s, n, CPQ_N));
        chk(lw == exp_low(s, n, CPQ_W), {req, " 512b"}, lw, exp_low(s, n, CPQ_W));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int qvals[3] = '{0, 1, 3};
        int gvals[3] = '{0, 2, 3};
        int idx = 0;
        int s, ln, lw;
        for (int i = 0; i < NP; i++) qq[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(&ok_n && &ok_w, "R1 during reset", int'(ok_n), 255);
        rst_n = 1'b1;
        @(negedge clk);
        chk(&ok_n && &ok_w, "R1 after reset", int'(ok_w), 255);

        // R2/R3/R4/R5: sweep enables and values over rotating queues
        for (int qe = 0; qe < 2; qe++) begin
            for (int ge = 0; ge < 2; ge++) begin
                for (int qi = 0; qi < 3; qi++) begin
                    for (int gi = 0; gi < 3; gi++) begin
                        int q, n;
                        q = idx % NP;
                        idx++;
                        queue_hold_en = '0;
                        queue_hold_en[q] = qe[0];
                        qq[q] = QW'(qvals[qi]);
                        global_hold_en = ge[0];
                        global_hold_quanta = QW'(gvals[gi]);
                        n = eff(qe[0], qvals[qi], ge[0], gvals[gi]);
                        xoff_req[q] = 1'b1;
                        @(negedge clk);
                        send_and_measure(q, n, (n == 0) ? "R3 zero hold" : "R2 R4 R5 hold max");
                        xoff_req[q] = 1'b0;
                        qq[q] = '0;
                        @(negedge clk);
                    end
                end
            end
        end
        global_hold_en = 1'b0;
        queue_hold_en = '0;

        // R6: drop request mid-hold, then re-request without a send
        queue_hold_en[2] = 1'b1; qq[2] = 16'd6;
        xoff_req[2] = 1'b1;
        @(negedge clk);
        frame_sent[2] = 1'b1;
        @(negedge clk);
        frame_sent[2] = 1'b0;
        @(negedge clk);
        chk(!ok_n[2] && !ok_w[2], "R6 hold active before drop", int'(ok_n[2]), 0);
        xoff_req[2] = 1'b0;
        @(negedge clk);
        chk(ok_n[2] && ok_w[2], "R6 release on drop", int'(ok_n[2]), 1);
        xoff_req[2] = 1'b1;
        ln = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!ok_n[2] || !ok_w[2]) ln++;
        end
        chk(ln == 0, "R6 count discarded", ln, 0);
        xoff_req[2] = 1'b0;
        @(negedge clk);

        // R8: send with no request is ignored
        queue_hold_en[4] = 1'b1; qq[4] = 16'd5;
        frame_sent[4] = 1'b1;
        @(negedge clk);
        frame_sent[4] = 1'b0;
        chk(ok_n[4] && ok_w[4], "R8 send ignored", int'(ok_n[4]), 1);
        xoff_req[4] = 1'b1;
        ln = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (!ok_n[4] || !ok_w[4]) ln++;
        end
        chk(ln == 0, "R8 no hold after later request", ln, 0);
        xoff_req[4] = 1'b0;
        @(negedge clk);

        // R9: second send during hold reloads
        queue_hold_en[5] = 1'b1; qq[5] = 16'd4;
        xoff_req[5] = 1'b1;
        @(negedge clk);
        frame_sent[5] = 1'b1;
        @(negedge clk);
        frame_sent[5] = 1'b0;
        @(negedge clk);
        chk(!ok_n[5] && !ok_w[5], "R9 first hold active", int'(ok_w[5]), 0);
        send_and_measure(5, 4, "R9 reload");
        xoff_req[5] = 1'b0;
        @(negedge clk);

        // R7: hold on priority 0 leaves priority 1 untouched
        queue_hold_en = '0;
        queue_hold_en[0] = 1'b1; qq[0] = 16'd5;
        queue_hold_en[1] = 1'b1; qq[1] = 16'd0;
        xoff_req[1:0] = 2'b11;
        @(negedge clk);
        s = cyc + 1;
        frame_sent[0] = 1'b1;
        @(negedge clk);
        frame_sent[0] = 1'b0;
        ln = 0; lw = 0;
        for (int k = 0; k < 30; k++) begin
            if (!ok_n[0]) ln++;
            if (!ok_n[1] || !ok_w[1] || (ok_n[7:2] != '1) || (ok_w[7:2] != '1)) lw++;
            @(negedge clk);
        end
        chk(lw == 0, "R7 other priorities stay open", lw, 0);
        chk(ln == exp_low(s, 5, CPQ_N), "R7 held priority timing", ln, exp_low(s, 5, CPQ_N));
        xoff_req = '0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule